// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets software reach the management registers of an external Ethernet PHY over the two-wire MDIO bus. Software uses one 32-bit command and status word. A single store to that word supplies the PHY address, the register address, the direction and, for a write, the 16 payload bits, and that store starts the transaction. The controller then shifts out a clause-22 management frame on MDIO and generates MDC from the system clock.

While a frame is on the wire the word reports busy. When a read has finished, a read-valid flag is set and the low half of the word holds the value returned by the PHY. A second word holds the port's own PHY address, limited to five bits, for software to keep and read back. MDIO leaves the block as a data bit and a drive enable so that the pad can be tristated. MDIO is released during the turnaround and data phases of a read.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the command word (address 0) and the PHY-address word (address 1) both read as zero, MDC is low and the MDIO drive enable is low.
- R2: MDC is low whenever no frame is running. While a frame runs, each frame bit lasts `DIV` system clocks, with MDC low for the first half and high for the second.
- R3: Command word layout: bits 15:0 data, 20:16 register address, 25:21 PHY address, 26 direction (1 = read, 0 = write), 27 read-valid, 28 busy, 31:29 read as zero. A write command sends, MSB first, 32 ones, `01`, opcode `01`, the PHY address, the register address, turnaround `10` and the 16 data bits, driving MDIO for all 64 bits.
- R4: A read command sends opcode `10` and drives MDIO only for the first 46 bits. The drive enable is low for the two turnaround bits and the 16 data bits.
- R5: During a read, MDIO is sampled at each rising MDC edge of frame bits 48 to 63, MSB first. After the frame, bits 15:0 hold the sampled value and bit 27 is set.
- R6: Busy is set from the cycle after an accepted command store and stays set for exactly 64 × `DIV` clocks.
- R7: A store to the command word while busy is set is ignored. The running frame and the stored address and direction fields do not change.
- R8: An accepted command clears read-valid. Read-valid is never set while busy.
- R9: The PHY-address word keeps bits 4:0 of a store and reads zero above them. It can be written at any time, including while a frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register store strobe |
| regAddr | input | 1 | Word select: 0 command/status, 1 own PHY address |
| regWrData | input | 32 | Store data |
| regRdData | output | 32 | Read data of the selected word |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value when driven |
| mdioOe | output | 1 | MDIO drive enable |
| mdioIn | input | 1 | MDIO value seen at the pad |

## Verification
The hardest case to reach from the ports is a command store that lands while a frame is already on the wire, because it has to be timed inside the busy window. The bench issues a second store a few clocks after a start and reads the fields back while busy is still set. When the frame ends, it compares all 64 captured bits with the first command's frame. The bench also models the PHY's reply by counting MDC rising edges, which makes it possible to check that sampling happens on the right edges. It sweeps every PHY address in both directions, each with a different register address and payload.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS       = 64;
  localparam int READ_DRIVEN_BITS = 46;
  localparam int READ_DATA_FIRST  = 48;
  localparam int F_REG_LSB        = 16;
  localparam int F_PHY_LSB        = 21;
  localparam int F_OP             = 26;
  localparam int F_RVALID         = 27;
  localparam int F_BUSY           = 28;

  typedef struct packed {
    logic start;    // command accepted, load frame
    logic shift;    // advance to the next frame bit
    logic capture;  // rising MDC during a read data bit
    logic finish;   // last bit period has ended
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        isRead,
  output mdioStrobe_t strobe,
  output logic        busy,
  output logic        mdc,
  output logic        mdioOe
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] DIV_LAST  = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_CNT  = CW'(DIV / 2);
  localparam logic [CW-1:0] HALF_LAST = CW'(DIV / 2 - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] RD_DRIVEN = BW'(READ_DRIVEN_BITS);
  localparam logic [BW-1:0] RD_FIRST  = BW'(READ_DATA_FIRST);

  logic [CW-1:0] divCnt;
  logic [BW-1:0] bitCnt;
  logic          bitEnd;

  assign bitEnd         = busy && (divCnt == DIV_LAST);
  assign strobe.start   = startReq && !busy;
  assign strobe.shift   = bitEnd && (bitCnt != BIT_LAST);
  assign strobe.finish  = bitEnd && (bitCnt == BIT_LAST);
  assign strobe.capture = busy && (divCnt == HALF_LAST) && (bitCnt >= RD_FIRST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (strobe.start) begin
      busy   <= 1'b1;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (bitEnd) begin
        divCnt <= '0;
        if (bitCnt == BIT_LAST) busy <= 1'b0;
        else                    bitCnt <= bitCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mdc    = busy && (divCnt >= HALF_CNT);
  assign mdioOe = busy && (!isRead || (bitCnt < RD_DRIVEN));

  assert_idle_mdc_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc) else $error("MDC toggling while idle");

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe) else $error("MDIO driven while idle");

  assert_busy_needs_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq)) else $error("busy rose without a command");
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t strobe,
  input  logic        busy,
  input  logic        startReq,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        isRead,
  output logic        mdioOut,
  input  logic        mdioIn
);
  logic [FRAME_BITS-1:0] frame;
  logic [15:0] dataField;
  logic [4:0]  regField;
  logic [4:0]  phyField;
  logic [4:0]  ownPhy;
  logic        readValid;
  logic        cmdRead;
  logic        unusedHigh;

  assign cmdRead    = regWrData[F_OP];
  assign unusedHigh = ^regWrData[31:27];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame     <= '0;
      dataField <= '0;
      regField  <= '0;
      phyField  <= '0;
      isRead    <= 1'b0;
      readValid <= 1'b0;
    end else if (strobe.start) begin
      dataField <= regWrData[15:0];
      regField  <= regWrData[F_REG_LSB +: 5];
      phyField  <= regWrData[F_PHY_LSB +: 5];
      isRead    <= cmdRead;
      readValid <= 1'b0;
      frame <= {32'hFFFF_FFFF, 2'b01,
                cmdRead ? 2'b10 : 2'b01,
                regWrData[F_PHY_LSB +: 5], regWrData[F_REG_LSB +: 5],
                cmdRead ? 2'b11 : 2'b10,
                cmdRead ? 16'hFFFF : regWrData[15:0]};
    end else begin
      if (strobe.shift)               frame     <= {frame[FRAME_BITS-2:0], 1'b1};
      if (strobe.capture && isRead)   dataField <= {dataField[14:0], mdioIn};
      if (strobe.finish)              readValid <= isRead;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      ownPhy <= '0;
    else if (regWrEn && regAddr)    ownPhy <= regWrData[4:0];
  end

  assign mdioOut = frame[FRAME_BITS-1];

  always_comb begin
    if (regAddr) regRdData = {27'd0, ownPhy};
    else         regRdData = {3'd0, busy, readValid, isRead, phyField, regField, dataField};
  end

  assert_valid_not_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !readValid) else $error("read-valid set during a frame");

  assert_store_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> ($stable(phyField) && $stable(regField) && $stable(isRead)))
    else $error("command fields changed while busy");
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobe_t strobe;
  logic busy;
  logic isRead;
  logic startReq;

  assign startReq = regWrEn && !regAddr;

  mdio_ctrl #(.DIV(DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isRead(isRead),
    .strobe(strobe), .busy(busy), .mdc(mdc), .mdioOe(mdioOe)
  );

  mdio_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .startReq(startReq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .isRead(isRead), .mdioOut(mdioOut), .mdioIn(mdioIn)
  );
endmodule

// File: tb/mdio_mgmt_tb.sv
module mdio_mgmt_tb_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;
  logic [15:0] respWord = 16'h0;

  int total = 0;
  int bad = 0;
  int edgeIdx = 0;
  logic [63:0] capF = '0;
  logic [63:0] capOe = '0;

  always #2 clk = ~clk;

  mdio_mgmt #(.DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: bit index within a frame is the count of MDC rising edges mod 64
  assign mdioIn = ((edgeIdx % 64) >= 48) ? respWord[63 - (edgeIdx % 64)] : 1'b1;

  always @(posedge mdc) begin
    capF[63 - (edgeIdx % 64)]  <= mdioOut;
    capOe[63 - (edgeIdx % 64)] <= mdioOe;
    edgeIdx <= edgeIdx + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regStore(input logic a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 1'b0;
  endtask

  function automatic logic [31:0] cmdWord(input bit rd, input int phy, input int rg, input logic [15:0] d);
    return {5'd0, rd, 5'(phy), 5'(rg), d};
  endfunction

  function automatic logic [63:0] expFrame(input bit rd, input int phy, input int rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, 5'(phy), 5'(rg),
            rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : d};
  endfunction

  task automatic waitIdle(output int cycles);
    cycles = 0;
    while (regRdData[28]) begin
      cycles++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic checkFrame(input bit rd, input int phy, input int rg, input logic [15:0] d, input string req);
    logic [63:0] ef, eo;
    ef = expFrame(rd, phy, rg, d);
    eo = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
    chk((capF & eo) == (ef & eo), req, capF & eo, ef & eo);
    chk(capOe == eo, req, capOe, eo);
  endtask

  initial begin
    #700000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(regRdData == 32'h0, "R1 cmd word", 64'(regRdData), 64'h0);
    chk(mdc == 1'b0 && mdioOe == 1'b0, "R1 pins", {62'd0, mdc, mdioOe}, 64'h0);
    regAddr = 1'b1; #1;
    chk(regRdData == 32'h0, "R1 phy word", 64'(regRdData), 64'h0);
    regAddr = 1'b0;

    // R9 own PHY address masking
    regStore(1'b1, 32'hFFFF_FFE5);
    regAddr = 1'b1; #1;
    chk(regRdData == 32'h5, "R9 mask", 64'(regRdData), 64'h5);
    regAddr = 1'b0;
    regStore(1'b1, 32'hFFFF_FFFF);
    regAddr = 1'b1; #1;
    chk(regRdData == 32'h1F, "R9 all ones", 64'(regRdData), 64'h1F);
    regAddr = 1'b0;

    // R3/R6 write sweep over every PHY address
    for (int p = 0; p < 32; p++) begin
      int rg;
      rg = (p * 7 + 3) % 32;
      d = 16'(p * 16'h0813) ^ 16'hA5C3;
      regStore(1'b0, cmdWord(1'b0, p, rg, d));
      waitIdle(cyc);
      chk(cyc == 64 * DIV, "R6 busy length", 64'(cyc), 64'(64 * DIV));
      checkFrame(1'b0, p, rg, d, "R3 write frame");
      chk(regRdData == cmdWord(1'b0, p, rg, d), "R3 readback", 64'(regRdData), 64'(cmdWord(1'b0, p, rg, d)));
      chk(mdc == 1'b0, "R2 idle mdc", 64'(mdc), 64'h0);
    end

    // R4/R5 read sweep
    for (int p = 0; p < 32; p++) begin
      int rg;
      rg = 31 - p;
      respWord = 16'(p * 16'h1357) ^ 16'h6C16;
      regStore(1'b0, cmdWord(1'b1, p, rg, 16'h0));
      waitIdle(cyc);
      chk(cyc == 64 * DIV, "R6 busy length read", 64'(cyc), 64'(64 * DIV));
      checkFrame(1'b1, p, rg, 16'h0, "R4 read frame");
      chk(regRdData[15:0] == respWord, "R5 read data", 64'(regRdData[15:0]), 64'(respWord));
      chk(regRdData[28:26] == 3'b011, "R5 flags", 64'(regRdData[28:26]), 64'h3);
    end

    // R8 new command clears read-valid
    regStore(1'b0, cmdWord(1'b0, 9, 4, 16'h1234));
    chk(regRdData[27] == 1'b0 && regRdData[28] == 1'b1, "R8 cleared", 64'(regRdData[28:27]), 64'h2);
    waitIdle(cyc);
    chk(regRdData[27] == 1'b0, "R8 write keeps clear", 64'(regRdData[27]), 64'h0);

    // R7 store while busy is ignored
    regStore(1'b0, cmdWord(1'b0, 17, 22, 16'hBEEF));
    repeat (10) @(negedge clk);
    regStore(1'b0, cmdWord(1'b1, 3, 5, 16'h0000));
    chk(regRdData[25:16] == {5'd17, 5'd22} && regRdData[26] == 1'b0, "R7 fields kept",
        64'(regRdData[26:16]), 64'({1'b0, 5'd17, 5'd22}));
    regStore(1'b1, 32'h0000_0007);
    regAddr = 1'b1; #1;
    chk(regRdData == 32'h7, "R9 store while busy", 64'(regRdData), 64'h7);
    regAddr = 1'b0; #1;
    waitIdle(cyc);
    checkFrame(1'b0, 17, 22, 16'hBEEF, "R7 frame unchanged");
    chk(regRdData == cmdWord(1'b0, 17, 22, 16'hBEEF), "R7 readback", 64'(regRdData), 64'(cmdWord(1'b0, 17, 22, 16'hBEEF)));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule